// File: doc/BRIEF.md
# Edge-Triggered Timer Capture Unit

This block timestamps transitions on an external input. A free-running 16-bit timebase counts system clocks while its run input is high. The external pin passes through a two-stage synchronizer and an edge detector. When a selected transition is seen, the current counter value is latched into a 16-bit capture register and a sticky capture flag is set. The flag, gated by an interrupt enable, drives an interrupt request.

Software uses a small byte-wide register port. Through it, software picks the rising and falling edge enables and the interrupt enable, reads the two capture bytes, reads the synchronized pin level, and clears the flag. The pin level lets software tell which edge caused a capture when both edges are enabled. The pin must hold each level for at least two clock cycles to be recognized.

Top module: `edge_capture_unit`

## Requirements
- R1: A capture copies the counter value held during the cycle in which the edge is detected into the capture register. Capture bits 7:0 read at address 2 and bits 15:8 read at address 3, and both bytes update in the same clock cycle. The capture is visible after the third rising clock edge that follows a pin change.
- R2: Control register (address 0) bit 0 enables capture on a rising edge and bit 1 enables capture on a falling edge. With both bits set, either transition captures. A transition whose enable bit is 0 does not change the capture register.
- R3: Every capture sets the capture flag, which is status register (address 1) bit 0.
- R4: `irq_o` is 1 exactly when the capture flag is 1 and control bit 2 (interrupt enable) is 1.
- R5: The flag stays set until software writes the status register with bit 0 equal to 0. Writing bit 0 equal to 1 leaves the flag unchanged.
- R6: Status bit 1 reads the synchronized pin level, which follows the pin two clock edges later.
- R7: With control bits 1:0 both 0, pin transitions change neither the capture register nor the flag.
- R8: If a capture and a flag-clearing write fall in the same cycle, the flag ends at 1.
- R9: The counter increments by one on each clock while `run_i` is 1, holds while `run_i` is 0, and wraps from 0xFFFF to 0x0000.
- R10: Reset clears the counter, capture register, flag, control bits and synchronizer stages. After reset every register reads 0 and `irq_o` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| run_i | input | 1 | Timebase count enable |
| cap_pin_i | input | 1 | External capture input, asynchronous |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register write address |
| wr_data_i | input | 8 | Register write data |
| rd_addr_i | input | 2 | Register read address |
| rd_data_o | output | 8 | Register read data, combinational |
| irq_o | output | 1 | Interrupt request |

## Verification
A wrong synchronizer or edge-detector state appears at the ports one or two cycles late. It shows as a capture value off by the counter's step, or as a missing or extra flag set. Reading the capture bytes right after the third clock edge exposes it. A corrupted flag shows in `irq_o` and status bit 0 on the next cycle. A timebase fault shows in the difference between successive captures, including two captures exactly 65536 cycles apart, which must read equal.

// File: rtl/ecap_pkg.sv
package ecap_pkg;

  localparam int unsigned REG_CTRL  = 0;
  localparam int unsigned REG_STAT  = 1;
  localparam int unsigned REG_CAP0  = 2;

  localparam int unsigned STAT_FLAG_BIT  = 0;
  localparam int unsigned STAT_LEVEL_BIT = 1;

  typedef struct packed {
    logic irq_en;
    logic fall_en;
    logic rise_en;
  } ctrl_t;

  localparam int unsigned CTRL_W = $bits(ctrl_t);

endpackage

// File: rtl/ecap_timebase.sv
module ecap_timebase #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  output logic [CNT_W-1:0] count_o
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (run_i) cnt_q <= cnt_q + 1'b1;
  end

  assign count_o = cnt_q;

  a_r9_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && (&cnt_q)) |=> (cnt_q == '0));

  a_r9_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> $stable(cnt_q));

endmodule

// File: rtl/ecap_pin_sync.sv
module ecap_pin_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  output logic level_o,
  output logic rise_o,
  output logic fall_o
);

  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q[g] <= 1'b0;
        else         sync_q[g] <= pin_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q[g] <= 1'b0;
        else         sync_q[g] <= sync_q[g-1];
      end
    end
  end

  // previous synchronized sample for edge compare
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= sync_q[STAGES-1];
  end

  assign level_o = sync_q[STAGES-1];
  assign rise_o  =  level_o & ~prev_q;
  assign fall_o  = ~level_o &  prev_q;

  a_r6_rise_after_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o);

  a_r6_fall_after_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fall_o |=> !fall_o);

endmodule

// File: rtl/ecap_channel.sv
module ecap_channel
  import ecap_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rise_i,
  input  logic             fall_i,
  input  ctrl_t            ctrl_i,
  input  logic             clr_i,
  input  logic [CNT_W-1:0] count_i,
  output logic [CNT_W-1:0] cap_o,
  output logic             flag_o,
  output logic             fire_o
);

  logic [CNT_W-1:0] cap_q;
  logic             flag_q;
  logic             fire;

  assign fire = (rise_i & ctrl_i.rise_en) | (fall_i & ctrl_i.fall_en);

  // whole word loads in one cycle: halves stay coherent
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   cap_q <= '0;
    else if (fire) cap_q <= count_i;
  end

  // set beats clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    flag_q <= 1'b0;
    else if (fire)  flag_q <= 1'b1;
    else if (clr_i) flag_q <= 1'b0;
  end

  assign cap_o  = cap_q;
  assign flag_o = flag_q;
  assign fire_o = fire;

  a_r1_cap_value: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire |=> (cap_q == $past(count_i)));

  a_r3_flag_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire |=> flag_q);

  a_r5_flag_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_q && !clr_i) |=> flag_q);

  a_r7_no_select: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctrl_i.rise_en && !ctrl_i.fall_en) |=> ($stable(cap_q) && (flag_q || !$past(flag_q) || $past(clr_i))));

endmodule

// File: rtl/ecap_regif.sv
module ecap_regif
  import ecap_pkg::*;
#(
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned ADDR_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o,
  input  logic [CNT_W-1:0]  cap_i,
  input  logic              flag_i,
  input  logic              level_i,
  output ctrl_t             ctrl_o,
  output logic              clr_o,
  output logic              irq_o
);

  localparam int unsigned NBYTES = CNT_W / DATA_W;

  ctrl_t             ctrl_q;
  logic [DATA_W-1:0] cap_bytes [NBYTES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ctrl_q <= '0;
    else if (wr_en_i && (wr_addr_i == ADDR_W'(REG_CTRL)))
      ctrl_q <= wr_data_i[CTRL_W-1:0];
  end

  assign clr_o = wr_en_i && (wr_addr_i == ADDR_W'(REG_STAT)) && !wr_data_i[STAT_FLAG_BIT];

  for (genvar g = 0; g < NBYTES; g++) begin : g_byte
    assign cap_bytes[g] = cap_i[g*DATA_W +: DATA_W];
  end

  always_comb begin
    rd_data_o = '0;
    if (rd_addr_i == ADDR_W'(REG_CTRL)) begin
      rd_data_o[CTRL_W-1:0] = ctrl_q;
    end else if (rd_addr_i == ADDR_W'(REG_STAT)) begin
      rd_data_o[STAT_FLAG_BIT]  = flag_i;
      rd_data_o[STAT_LEVEL_BIT] = level_i;
    end else begin
      for (int i = 0; i < NBYTES; i++)
        if (rd_addr_i == ADDR_W'(REG_CAP0 + i)) rd_data_o = cap_bytes[i];
    end
  end

  assign ctrl_o = ctrl_q;
  assign irq_o  = flag_i & ctrl_q.irq_en;

endmodule

// File: rtl/edge_capture_unit.sv
module edge_capture_unit
  import ecap_pkg::*;
#(
  parameter int unsigned CNT_W       = 16,
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned ADDR_W      = 2,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic              cap_pin_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              irq_o
);

  logic [CNT_W-1:0] count;
  logic [CNT_W-1:0] cap;
  logic             level, rise, fall, flag, clr, fire;
  ctrl_t            ctrl;

  ecap_timebase #(.CNT_W(CNT_W)) u_timebase (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (run_i),
    .count_o(count)
  );

  ecap_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pin_i  (cap_pin_i),
    .level_o(level),
    .rise_o (rise),
    .fall_o (fall)
  );

  ecap_channel #(.CNT_W(CNT_W)) u_channel (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rise_i (rise),
    .fall_i (fall),
    .ctrl_i (ctrl),
    .clr_i  (clr),
    .count_i(count),
    .cap_o  (cap),
    .flag_o (flag),
    .fire_o (fire)
  );

  ecap_regif #(.CNT_W(CNT_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regif (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_en_i),
    .wr_addr_i(wr_addr_i),
    .wr_data_i(wr_data_i),
    .rd_addr_i(rd_addr_i),
    .rd_data_o(rd_data_o),
    .cap_i    (cap),
    .flag_i   (flag),
    .level_i  (level),
    .ctrl_o   (ctrl),
    .clr_o    (clr),
    .irq_o    (irq_o)
  );

  a_r8_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire && clr) |=> flag);

  a_r4_irq_needs_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> (flag && ctrl.irq_en));

endmodule

// File: tb/edge_capture_unit_tb.sv
module edge_capture_unit_tb;

  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       run = 1'b0;
  logic       pin = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [1:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic       irq;

  int checks = 0;
  int errors = 0;
  logic [15:0] model_cnt;
  logic [15:0] exp_q [$];
  logic [15:0] last_exp = '0;

  always #(CLK_P/2) clk = ~clk;

  edge_capture_unit u_dut (
    .clk_i(clk), .rst_ni(rst_n), .run_i(run), .cap_pin_i(pin),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .rd_addr_i(rd_addr), .rd_data_o(rd_data), .irq_o(irq)
  );

  // reference timebase
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n)   model_cnt <= '0;
    else if (run) model_cnt <= model_cnt + 16'd1;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    rd_addr = a;
    #1;
    d = rd_data;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // driver: called at a falling clock edge; pushes the expected capture
  task automatic edge_to(input logic lvl, input bit expect_cap);
    pin = lvl;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    if (expect_cap) exp_q.push_back(model_cnt);
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic read_cap(output logic [15:0] v);
    logic [7:0] lo, hi;
    rd(2'd2, lo);
    rd(2'd3, hi);
    v = {hi, lo};
  endtask

  // monitor: pops the scoreboard and compares the capture register
  task automatic monitor_cap(input string req);
    logic [15:0] v, e;
    read_cap(v);
    if (exp_q.size() > 0) begin
      e = exp_q.pop_front();
      last_exp = e;
    end else begin
      e = last_exp;
    end
    check(v == e, req, v, e);
  endtask

  task automatic expect_stat(input logic [7:0] e, input string req);
    logic [7:0] d;
    rd(2'd1, d);
    check(d == e, req, d, e);
  endtask

  initial begin
    #(CLK_P*150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0]  d;
    logic [15:0] a_val, b_val;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R10 reset state
    for (int i = 0; i < 4; i++) begin
      rd(i[1:0], d);
      check(d == 8'h00, "R10 reset register", d, 0);
    end
    check(irq == 1'b0, "R10 reset irq", irq, 0);

    // R2 rising only, irq enabled
    wr(2'd0, 8'b101);
    rd(2'd0, d);
    check(d == 8'h05, "R2 ctrl readback", d, 5);
    run = 1'b1;
    repeat (7) @(negedge clk);
    edge_to(1'b1, 1'b1);
    monitor_cap("R1 rising capture");
    expect_stat(8'h03, "R3 flag set and R6 level high");
    check(irq == 1'b1, "R4 irq with enable", irq, 1);
    edge_to(1'b0, 1'b0);
    monitor_cap("R2 falling ignored when disabled");
    expect_stat(8'h01, "R6 level low");

    // R5 clear semantics
    wr(2'd1, 8'h00);
    expect_stat(8'h00, "R5 software clear");
    check(irq == 1'b0, "R4 irq drops with flag", irq, 0);
    edge_to(1'b1, 1'b1);
    monitor_cap("R1 second rising capture");
    wr(2'd1, 8'h01);
    expect_stat(8'h03, "R5 write one keeps flag");
    repeat (20) @(negedge clk);
    expect_stat(8'h03, "R5 flag sticky");
    wr(2'd0, 8'b001);
    check(irq == 1'b0, "R4 irq masked", irq, 0);
    wr(2'd1, 8'h00);

    // R2 falling only
    wr(2'd0, 8'b010);
    repeat (3) @(negedge clk);
    edge_to(1'b0, 1'b1);
    monitor_cap("R2 falling capture");
    expect_stat(8'h01, "R3 flag on falling capture");
    edge_to(1'b1, 1'b0);
    monitor_cap("R2 rising ignored when disabled");

    // R2 both edges, direction via R6
    wr(2'd0, 8'b011);
    edge_to(1'b0, 1'b1);
    monitor_cap("R2 both edges falling");
    expect_stat(8'h01, "R6 level shows falling cause");
    repeat (5) @(negedge clk);
    edge_to(1'b1, 1'b1);
    monitor_cap("R2 both edges rising");
    expect_stat(8'h03, "R6 level shows rising cause");

    // R7 no edge selected
    wr(2'd0, 8'b000);
    wr(2'd1, 8'h00);
    edge_to(1'b0, 1'b0);
    edge_to(1'b1, 1'b0);
    monitor_cap("R7 no capture without enables");
    expect_stat(8'h02, "R7 flag unaffected");

    // R8 capture and clear in the same cycle
    wr(2'd0, 8'b010);
    pin = 1'b0;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    exp_q.push_back(model_cnt);
    wr(2'd1, 8'h00);
    monitor_cap("R8 capture during clear");
    expect_stat(8'h01, "R8 set wins over clear");

    // R9 hold while run low
    wr(2'd0, 8'b011);
    run = 1'b0;
    @(negedge clk);
    edge_to(1'b1, 1'b1);
    monitor_cap("R9 capture with run low");
    read_cap(a_val);
    repeat (9) @(negedge clk);
    edge_to(1'b0, 1'b1);
    monitor_cap("R9 capture with run low again");
    read_cap(b_val);
    check(a_val == b_val, "R9 counter holds", b_val, a_val);

    // R9 wrap: two snapshots exactly 65536 counts apart read equal
    run = 1'b1;
    edge_to(1'b1, 1'b1);
    monitor_cap("R9 capture before wrap");
    read_cap(a_val);
    repeat (65533) @(negedge clk);
    edge_to(1'b0, 1'b1);
    monitor_cap("R9 capture after wrap");
    read_cap(b_val);
    check(a_val == b_val, "R9 wrap modulo 65536", b_val, a_val);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule